// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps a record of instructions in the order they were issued, so that machine state is changed strictly in that order. The issue stage allocates one slot per instruction and receives a tag for it. Functional units later report results against that tag, in any order and whenever they finish. A result is written to the register file only when its slot is the oldest live one. Only one slot retires per cycle, through a single registered write port.

Each slot holds a destination register number, the result value, and three flags: finished, faulted and mispredicted. A faulted oldest slot is never written. It and every younger slot are dropped, and a one-cycle flush pulse with cause code 01 is sent out. A mispredicted oldest slot is written first. Then every younger slot is dropped, and the flush pulse carries cause code 10. After either flush, allocation resumes at the slot just after the last retired one.

Top module: `inorder_retire_buf`

## Requirements
- R1: After synchronous reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we` and `flush` are 0.
- R2: Each accepted allocation returns as `alloc_tag` the slot index it occupies. Successive indices rise by one modulo DEPTH (8 by default), so index 7 is followed by index 0.
- R3: With DEPTH slots occupied, `alloc_ready` is 0. An allocation request made while `alloc_ready` is 0 is ignored and does not move `alloc_tag`.
- R4: Results may be completed in any order, but register writes appear in allocation order.
- R5: The oldest slot retires only after its result has been completed. At most one register write occurs per cycle. A retirement is visible on `rf_we`/`rf_addr`/`rf_data` one clock after the retiring cycle.
- R6: A faulted oldest slot produces no register write. It produces `flush`=1 for exactly one cycle with `flush_cause`=2'b01, and no younger slot is ever written. The next allocation gets the faulted slot's index.
- R7: A mispredicted oldest slot is written, and in the same cycle `flush`=1 with `flush_cause`=2'b10. No younger slot is written, and the next allocation gets the mispredicted slot's index plus one.
- R8: An allocation and a retirement in the same cycle leave occupancy unchanged.
- R9: A completion whose tag names an unoccupied slot is ignored. A slot allocated there later is not marked finished by it.
- R10: In the cycle a flush is being decided, `alloc_ready` is 0 and any allocation request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_dest | input | REGW | Destination register of the issuing instruction |
| alloc_ready | output | 1 | A slot can be accepted this cycle |
| alloc_tag | output | log2(DEPTH) | Index the next accepted allocation receives |
| cmp_valid | input | 1 | A functional unit reports a result |
| cmp_tag | input | log2(DEPTH) | Slot the result belongs to |
| cmp_data | input | DATAW | Result value |
| cmp_exc | input | 1 | Instruction raised a fault |
| cmp_mispred | input | 1 | Branch was mispredicted |
| rf_we | output | 1 | Register file write enable (registered) |
| rf_addr | output | REGW | Register file write address |
| rf_data | output | DATAW | Register file write data |
| flush | output | 1 | One-cycle pipeline flush pulse |
| flush_cause | output | 2 | 01 fault, 10 mispredict, 00 otherwise |

## Verification
Allocation at the tail and retirement at the head can fall in the same cycle. That collision is where an occupancy count is most easily corrupted. The bench fills seven slots and completes only the oldest. It holds an allocation request in the very cycle that slot retires. It then judges the result at the ports. `alloc_ready` must still be 1, and exactly one more allocation must turn it to 0. The later drain must write all entries in allocation order.

// File: rtl/irb_pkg.sv
package irb_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_EXC  = 2'b01,
    CAUSE_MISP = 2'b10
  } flush_cause_e;

endpackage

// File: rtl/irb_ptrs.sv
module irb_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_fire,
  input  logic            retire_fire,
  input  logic            flush_now,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [CNTW-1:0] count
);

  logic [IDXW-1:0] head_nx;

  assign head_nx = retire_fire ? head + 1'b1 : head;

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= head_nx;
      if (flush_now) begin
        tail  <= head_nx;
        count <= '0;
      end else begin
        if (alloc_fire) tail <= tail + 1'b1;
        case ({alloc_fire, retire_fire})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH)); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (count == CNTW'(DEPTH) && !retire_fire && !flush_now) |=> $stable(tail)); // R3

  AST_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && retire_fire && !flush_now) |=> $stable(count)); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_now |=> (count == '0 && tail == head)); // R6

endmodule

// File: rtl/irb_entries.sv
module irb_entries #(
  parameter int DEPTH = 8,
  parameter int REGW  = 5,
  parameter int DATAW = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic [IDXW-1:0]  alloc_idx,
  input  logic [REGW-1:0]  alloc_dest,
  input  logic             cmp_valid,
  input  logic [IDXW-1:0]  cmp_idx,
  input  logic [DATAW-1:0] cmp_data,
  input  logic             cmp_exc,
  input  logic             cmp_mispred,
  input  logic             retire_fire,
  input  logic             flush_now,
  input  logic [IDXW-1:0]  head_idx,
  output logic             head_valid,
  output logic             head_done,
  output logic             head_exc,
  output logic             head_misp,
  output logic [REGW-1:0]  head_dest,
  output logic [DATAW-1:0] head_data
);

  logic [DEPTH-1:0] valid_q, done_q, exc_q, misp_q;
  logic [REGW-1:0]  dest_q   [DEPTH];
  logic [DATAW-1:0] data_mem [DEPTH];
  logic             cmp_fire;

  assign cmp_fire = cmp_valid && valid_q[cmp_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      misp_q  <= '0;
    end else begin
      if (alloc_fire) begin
        valid_q[alloc_idx] <= 1'b1;
        done_q[alloc_idx]  <= 1'b0;
        exc_q[alloc_idx]   <= 1'b0;
        misp_q[alloc_idx]  <= 1'b0;
      end
      if (cmp_fire) begin
        done_q[cmp_idx] <= 1'b1;
        exc_q[cmp_idx]  <= cmp_exc;
        misp_q[cmp_idx] <= cmp_mispred;
      end
      if (retire_fire) valid_q[head_idx] <= 1'b0;
      if (flush_now)   valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) dest_q[alloc_idx] <= alloc_dest;
  end

  always_ff @(posedge clk) begin
    if (cmp_fire) data_mem[cmp_idx] <= cmp_data;
  end

  assign head_valid = valid_q[head_idx];
  assign head_done  = done_q[head_idx];
  assign head_exc   = exc_q[head_idx];
  assign head_misp  = misp_q[head_idx];
  assign head_dest  = dest_q[head_idx];
  assign head_data  = data_mem[head_idx];

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> !valid_q[alloc_idx]); // R3

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
  import irb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int REGW  = 5,
  parameter int DATAW = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic [REGW-1:0]  alloc_dest,
  output logic             alloc_ready,
  output logic [IDXW-1:0]  alloc_tag,
  input  logic             cmp_valid,
  input  logic [IDXW-1:0]  cmp_tag,
  input  logic [DATAW-1:0] cmp_data,
  input  logic             cmp_exc,
  input  logic             cmp_mispred,
  output logic             rf_we,
  output logic [REGW-1:0]  rf_addr,
  output logic [DATAW-1:0] rf_data,
  output logic             flush,
  output logic [1:0]       flush_cause
);

  localparam int CNTW = $clog2(DEPTH + 1);

  logic [IDXW-1:0]  head, tail;
  logic [CNTW-1:0]  count;
  logic             h_valid, h_done, h_exc, h_misp;
  logic [REGW-1:0]  h_dest;
  logic [DATAW-1:0] h_data;
  logic             h_ready, retire_fire, flush_now, alloc_fire;
  flush_cause_e     cause_now;

  assign h_ready     = h_valid && h_done;
  assign retire_fire = h_ready && !h_exc;
  assign flush_now   = h_ready && (h_exc || h_misp);
  assign cause_now   = !flush_now ? CAUSE_NONE : (h_exc ? CAUSE_EXC : CAUSE_MISP);
  assign alloc_ready = (count != CNTW'(DEPTH)) && !flush_now;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  irb_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst(rst),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire), .flush_now(flush_now),
    .head(head), .tail(tail), .count(count)
  );

  irb_entries #(.DEPTH(DEPTH), .REGW(REGW), .DATAW(DATAW)) ents_i (
    .clk(clk), .rst(rst),
    .alloc_fire(alloc_fire), .alloc_idx(tail), .alloc_dest(alloc_dest),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_tag), .cmp_data(cmp_data),
    .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred),
    .retire_fire(retire_fire), .flush_now(flush_now), .head_idx(head),
    .head_valid(h_valid), .head_done(h_done), .head_exc(h_exc), .head_misp(h_misp),
    .head_dest(h_dest), .head_data(h_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we       <= 1'b0;
      rf_addr     <= '0;
      rf_data     <= '0;
      flush       <= 1'b0;
      flush_cause <= CAUSE_NONE;
    end else begin
      rf_we       <= retire_fire;
      rf_addr     <= h_dest;
      rf_data     <= h_data;
      flush       <= flush_now;
      flush_cause <= cause_now;
    end
  end

  AST_HEAD_LIVE: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> h_valid); // R4

  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> !rf_we); // R5

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush); // R6

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    flush |-> $countones(flush_cause) == 1); // R6

  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (flush && flush_cause == CAUSE_EXC) |-> !rf_we); // R6

  AST_MISP_WRITES: assert property (@(posedge clk) disable iff (rst)
    (flush && flush_cause == CAUSE_MISP) |-> rf_we); // R7

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    flush_now |=> $stable(count) || count == '0); // R10

endmodule

// File: tb/inorder_retire_buf_tb.sv
module inorder_retire_buf_tb_top;

  localparam int DEPTH = 8;
  localparam int REGW  = 5;
  localparam int DATAW = 32;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst;
  logic             alloc_valid;
  logic [REGW-1:0]  alloc_dest;
  logic             alloc_ready;
  logic [IDXW-1:0]  alloc_tag;
  logic             cmp_valid;
  logic [IDXW-1:0]  cmp_tag;
  logic [DATAW-1:0] cmp_data;
  logic             cmp_exc, cmp_mispred;
  logic             rf_we;
  logic [REGW-1:0]  rf_addr;
  logic [DATAW-1:0] rf_data;
  logic             flush;
  logic [1:0]       flush_cause;

  inorder_retire_buf #(.DEPTH(DEPTH), .REGW(REGW), .DATAW(DATAW)) dut_i (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .flush(flush), .flush_cause(flush_cause)
  );

  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  int log_addr [64];
  int log_data [64];

  always @(negedge clk) begin
    if (!rst && rf_we && log_n < 64) begin
      log_addr[log_n] = int'(rf_addr);
      log_data[log_n] = int'(rf_data);
      log_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_alloc(input int dest, output int tag);
    alloc_valid = 1'b1;
    alloc_dest  = REGW'(dest);
    tag         = int'(alloc_tag);
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic do_cmp(input int tag, input int data, input bit exc, input bit misp);
    cmp_valid   = 1'b1;
    cmp_tag     = IDXW'(tag);
    cmp_data    = DATAW'(data);
    cmp_exc     = exc;
    cmp_mispred = misp;
    step();
    cmp_valid   = 1'b0;
    cmp_exc     = 1'b0;
    cmp_mispred = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    alloc_valid = 1'b0; alloc_dest = '0;
    cmp_valid = 1'b0; cmp_tag = '0; cmp_data = '0; cmp_exc = 1'b0; cmp_mispred = 1'b0;
    wait_n(3);
    rst = 1'b0;
    step();
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_tag", int'(alloc_tag), 0);
    chk("R1 rf_we", int'(rf_we), 0);
    chk("R1 flush", int'(flush), 0);
  endtask

  task automatic t_inorder();
    int tg [4];
    int order [4] = '{3, 1, 0, 2};
    log_n = 0;
    for (int i = 0; i < 4; i++) begin
      do_alloc(i + 1, tg[i]);
      chk("R2 tag sequence", tg[i], i);
    end
    do_cmp(tg[order[0]], 100 + order[0] + 1, 1'b0, 1'b0);
    do_cmp(tg[order[1]], 100 + order[1] + 1, 1'b0, 1'b0);
    wait_n(2);
    chk("R5 no retire before head done", log_n, 0);
    do_cmp(tg[order[2]], 100 + order[2] + 1, 1'b0, 1'b0);
    do_cmp(tg[order[3]], 100 + order[3] + 1, 1'b0, 1'b0);
    wait_n(6);
    chk("R4 write count", log_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 write order addr", log_addr[i], i + 1);
      chk("R4 write order data", log_data[i], 101 + i);
    end
  endtask

  task automatic t_full_balance();
    int tg;
    log_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(8 + i, tg);
      chk("R2 tag wraps", tg, (4 + i) % DEPTH);
    end
    chk("R3 full not ready", int'(alloc_ready), 0);
    alloc_valid = 1'b1; alloc_dest = 5'd31;
    step();
    alloc_valid = 1'b0;
    chk("R3 tail unmoved when full", int'(alloc_tag), 4);
    for (int i = DEPTH - 1; i >= 0; i--) do_cmp((4 + i) % DEPTH, 200 + i, 1'b0, 1'b0);
    wait_n(DEPTH + 3);
    chk("R3 drain count", log_n, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 reverse completion addr", log_addr[i], 8 + i);
      chk("R4 reverse completion data", log_data[i], 200 + i);
    end
    // R8: seven live slots, allocate while the oldest retires
    log_n = 0;
    for (int i = 0; i < 7; i++) do_alloc(16 + i, tg);
    do_cmp(4, 416, 1'b0, 1'b0);
    alloc_valid = 1'b1; alloc_dest = 5'd23;
    step();
    alloc_valid = 1'b0;
    chk("R8 occupancy kept, still ready", int'(alloc_ready), 1);
    do_alloc(24, tg);
    chk("R8 one more alloc fills", int'(alloc_ready), 0);
    for (int i = 1; i < DEPTH + 1; i++) do_cmp((4 + i) % DEPTH, 400 + 16 + i, 1'b0, 1'b0);
    wait_n(DEPTH + 3);
    chk("R8 drain count", log_n, 9);
    for (int i = 0; i < 9; i++) chk("R8 drain order", log_addr[i], 16 + i);
  endtask

  task automatic t_exc();
    int ta, tb, tc, td, tg;
    log_n = 0;
    do_alloc(5, ta);
    do_alloc(6, tb);
    do_alloc(7, tc);
    do_alloc(9, td);
    do_cmp(tc, 70, 1'b0, 1'b0);
    do_cmp(td, 90, 1'b0, 1'b0);
    do_cmp(tb, 60, 1'b1, 1'b0);
    do_cmp(ta, 50, 1'b0, 1'b0);
    step();
    chk("R5 retire of older slot", int'(rf_we), 1);
    chk("R10 ready low while flush decided", int'(alloc_ready), 0);
    alloc_valid = 1'b1; alloc_dest = 5'd20;
    step();
    alloc_valid = 1'b0;
    chk("R6 flush pulse", int'(flush), 1);
    chk("R6 cause fault", int'(flush_cause), 1);
    chk("R6 faulted slot not written", int'(rf_we), 0);
    step();
    chk("R6 flush one cycle", int'(flush), 0);
    chk("R6 tail back to faulted slot", int'(alloc_tag), tb);
    do_alloc(11, tg);
    do_cmp(tg, 110, 1'b0, 1'b0);
    wait_n(4);
    chk("R6 writes after fault", log_n, 2);
    chk("R6 older written", log_addr[0], 5);
    chk("R10 ignored alloc absent", log_addr[1], 11);
  endtask

  task automatic t_misp();
    int tp, tq;
    log_n = 0;
    do_alloc(12, tp);
    do_alloc(13, tq);
    do_cmp(tq, 1, 1'b0, 1'b0);
    do_cmp(tp, 85, 1'b0, 1'b1);
    step();
    chk("R7 branch written", int'(rf_we), 1);
    chk("R7 branch addr", int'(rf_addr), 12);
    chk("R7 branch data", int'(rf_data), 85);
    chk("R7 flush pulse", int'(flush), 1);
    chk("R7 cause mispredict", int'(flush_cause), 2);
    chk("R7 tail after branch", int'(alloc_tag), (tp + 1) % DEPTH);
    wait_n(4);
    chk("R7 younger discarded", log_n, 1);
  endtask

  task automatic t_invalid();
    int t0, tg;
    log_n = 0;
    t0 = int'(alloc_tag);
    do_cmp(t0, 170, 1'b0, 1'b0);
    do_alloc(14, tg);
    chk("R9 same slot reused", tg, t0);
    wait_n(4);
    chk("R9 stray completion ignored", log_n, 0);
    do_cmp(tg, 119, 1'b0, 1'b0);
    wait_n(3);
    chk("R9 proper completion writes", log_n, 1);
    chk("R9 data from real completion", log_data[0], 119);
  endtask

  initial begin
    t_reset();
    t_inorder();
    t_full_balance();
    t_exc();
    t_misp();
    t_invalid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule